// File: doc/BRIEF.md
# VCO Band Search Controller

This block chooses one of 24 oscillator bands for a frequency synthesizer. It does this by looking at a 3-bit code that describes the loop's tuning voltage. When automatic selection is on, a write to the low byte of the fractional divider starts a search. The search begins at a programmed seed band. After each band change the controller waits for a settle interval, then reads the tuning code and either accepts the band or steps to the next band, up or down.

Two flags report the outcome. The done flag is low while the search runs and high once it stops. The hit flag is high only after a successful search. On success the chosen band and the code that qualified it are copied into status readback registers.

When automatic selection is off, the band comes straight from the programmed seed value. In that mode software drives the ADC enable directly and can latch the current code into the readback register.

Top module: `vco_band_search`

## Requirements
- R1: After reset `search_done`=1, `search_hit`=0, `stat_band`=0 and `stat_code`=0.
- R2: While `auto_en`=0, `band_sel` equals `seed_band` and `search_hit` is 0.
- R3: A search starts only on a cycle with `auto_en`=1, `div_wr_en`=1 and `div_wr_idx`=2 (the fractional low byte). A write with index 0 (integer) or index 1 (fractional high byte) leaves `search_done` at 1 and `band_sel` unchanged.
- R4: Tune codes fall into three classes. 3'b010 and 3'b101 are search-locked, 3'b001 and 3'b110 are locked, and every other code is out of lock. Only a search-locked code is accepted. Acceptance ends the search with `search_done`=1 and `search_hit`=1, and writes the band into `stat_band` and the code into `stat_code`.
- R5: A rejected code of 000, 001, 011 or 100 moves to the next higher band. A rejected code of 110 or 111 moves to the next lower band.
- R6: The search fails if a step would pass band 23 going up or band 0 going down, or if the step direction reverses. Failure gives `search_done`=1 and `search_hit`=0, and `stat_band` and `stat_code` keep their previous values.
- R7: Each band is held for `settle_len` clock cycles before its code is sampled. A search that visits V bands raises `search_done` exactly `settle_len`×V cycles after the trigger edge, and `search_done` stays 0 until then.
- R8: A `settle_len` of 0 selects the default settle interval of 256 cycles.
- R9: A new trigger during a search restarts it from the current `seed_band`, and the step history is cleared.
- R10: A trigger with `seed_band` above 23 ends at once as a failure, and `search_done` never drops.
- R11: While `auto_en`=0, `adc_on` follows `adc_rd_en`. A pulse on `adc_latch` with `adc_rd_en`=1 copies `adc_code` into `stat_code`. With `adc_rd_en`=0 the latch pulse is ignored.
- R12: Dropping `auto_en` during a search aborts it on the next edge, with `search_done`=1 and `search_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_en | input | 1 | Automatic band selection enable |
| seed_band | input | 5 | Manual band, or starting band of a search |
| div_wr_en | input | 1 | Divider register write strobe |
| div_wr_idx | input | 2 | Divider register written: 0 integer, 1 fraction high, 2 fraction low |
| settle_len | input | 16 | Settle interval in cycles; 0 selects 256 |
| adc_code | input | 3 | Tuning-voltage ADC code |
| adc_rd_en | input | 1 | Manual ADC enable |
| adc_latch | input | 1 | Manual ADC latch request |
| band_sel | output | 5 | Band applied to the oscillator bank |
| adc_on | output | 1 | ADC enable |
| search_done | output | 1 | High when no search is running |
| search_hit | output | 1 | High after a successful search |
| stat_band | output | 5 | Band readback |
| stat_code | output | 3 | ADC code readback |

## Verification
The ADC model in the bench ties each band to a code using a target band. The search is run against several models:
- An ascending ramp and a descending ramp check that both step directions land on the target.
- The alternate locked code 3'b101 checks that both search-locked values are accepted.
- The middle codes 011 and 100 check that they step upward.
- A gap where the codes jump from 001 straight to 110 checks failure on reversal.
- A model that is all-low and one that is all-high check failure at the two ends of the bank.

The time from trigger to done is compared against settle_len × bands visited, which separates a correct settle count from an off-by-one.

// File: rtl/vas_pkg.sv
// Shared widths and types for the VCO band search controller.
// Assumes a bank of at most 32 bands and a 3-bit tune-voltage code.
package vas_pkg;
    localparam int BAND_W = 5;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        CLS_OUT  = 2'd0,
        CLS_LOCK = 2'd1,
        CLS_VAS  = 2'd2
    } lock_class_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } search_state_t;
endpackage

// File: rtl/vas_code_judge.sv
// Sorts a tune-voltage code into a lock class and gives the step direction.
// Purely combinational. Assumes the code is stable for the sampling cycle.
module vas_code_judge
    import vas_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output lock_class_t       cls,
    output logic              accept,
    output logic              step_up
);
    // Map each code to a class; codes not listed are out of lock.
    always_comb begin
        case (code)
            3'b010, 3'b101: cls = CLS_VAS;
            3'b001, 3'b110: cls = CLS_LOCK;
            default:        cls = CLS_OUT;
        endcase
    end

    // Accept only the search-locked class.
    assign accept = (cls == CLS_VAS);

    // A high tune voltage (110/111) steps down; every other code steps up.
    assign step_up = !(code == 3'b110 || code == 3'b111);
endmodule

// File: rtl/vas_settle_timer.sv
// Down-counter that paces the search: a load starts a settle interval of
// len cycles (0 selects DEFAULT_LEN), and expired is high in the last one.
// Assumes len does not change while a search is running.
module vas_settle_timer #(
    parameter int CNT_W       = 16,
    parameter int DEFAULT_LEN = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_eff;

    // Choose the programmed length, or the default when it is zero.
    assign len_eff = (len == '0) ? CNT_W'(DEFAULT_LEN) : len;

    // Load, then count down while the search is settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len_eff - CNT_W'(1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Flag the final cycle of the interval.
    assign expired = run && (cnt == '0);
endmodule

// File: rtl/vas_search_fsm.sv
// Band search sequencer. It starts at the seed band and moves one band per
// settle interval, following the code judge, until it accepts a band or
// fails. Assumes trig is a single-cycle qualified register-write strobe.
module vas_search_fsm
    import vas_pkg::*;
#(
    parameter int NUM_BANDS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trig,
    input  logic [BAND_W-1:0] seed,
    input  logic              expired,
    input  logic              accept,
    input  logic              step_up,
    output logic              busy,
    output logic              load_timer,
    output logic              success,
    output logic [BAND_W-1:0] cur_band,
    output logic              done_flag,
    output logic              hit_flag
);
    localparam logic [BAND_W-1:0] LAST = BAND_W'(NUM_BANDS - 1);

    search_state_t state;
    logic          dir_valid;
    logic          dir_up;
    logic          seed_ok;
    logic          judge;
    logic          fail_now;

    // Decode the conditions for start, sampling and failure.
    assign seed_ok  = (seed <= LAST);
    assign busy     = (state == ST_SETTLE);
    assign judge    = enable && !trig && busy && expired;
    assign fail_now = (dir_valid && (dir_up != step_up))
                    || (step_up && cur_band == LAST)
                    || (!step_up && cur_band == '0);
    assign success    = judge && accept;
    assign load_timer = (enable && trig && seed_ok)
                      || (judge && !accept && !fail_now);

    // Sequence the search and keep the done and hit flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_band  <= '0;
            dir_valid <= 1'b0;
            dir_up    <= 1'b0;
            done_flag <= 1'b1;
            hit_flag  <= 1'b0;
        end else if (!enable) begin
            state     <= ST_IDLE;
            dir_valid <= 1'b0;
            done_flag <= 1'b1;
            hit_flag  <= 1'b0;
        end else if (trig) begin
            hit_flag  <= 1'b0;
            dir_valid <= 1'b0;
            if (seed_ok) begin
                state     <= ST_SETTLE;
                cur_band  <= seed;
                done_flag <= 1'b0;
            end else begin
                state     <= ST_IDLE;
                done_flag <= 1'b1;
            end
        end else if (judge) begin
            if (accept) begin
                state     <= ST_IDLE;
                done_flag <= 1'b1;
                hit_flag  <= 1'b1;
            end else if (fail_now) begin
                state     <= ST_IDLE;
                done_flag <= 1'b1;
                hit_flag  <= 1'b0;
            end else begin
                cur_band  <= step_up ? cur_band + BAND_W'(1) : cur_band - BAND_W'(1);
                dir_valid <= 1'b1;
                dir_up    <= step_up;
            end
        end
    end

    AST_HIT_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_flag |-> done_flag); // R4
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_flag); // R7
    AST_BAND_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_band <= LAST)); // R10
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(trig)) |->
        (cur_band == $past(cur_band) || cur_band == $past(cur_band) + BAND_W'(1)
         || cur_band == $past(cur_band) - BAND_W'(1))); // R5
    AST_SETTLE_BEFORE_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && expired) |-> $past(busy)); // R7
    AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (done_flag && !hit_flag)); // R12
endmodule

// File: rtl/vco_band_search.sv
// Top of the VCO band search controller. It qualifies the divider write that
// starts a search, muxes manual and automatic band selection, and holds the
// band and code readback registers. Assumes adc_code comes from an external
// ADC that samples the tune voltage of the currently selected band.
module vco_band_search
    import vas_pkg::*;
#(
    parameter int NUM_BANDS      = 24,
    parameter int CNT_W          = 16,
    parameter int SETTLE_DEFAULT = 256,
    parameter int REG_IDX_W      = 2,
    parameter int FRAC_LO_IDX    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 auto_en,
    input  logic [BAND_W-1:0]    seed_band,
    input  logic                 div_wr_en,
    input  logic [REG_IDX_W-1:0] div_wr_idx,
    input  logic [CNT_W-1:0]     settle_len,
    input  logic [CODE_W-1:0]    adc_code,
    input  logic                 adc_rd_en,
    input  logic                 adc_latch,
    output logic [BAND_W-1:0]    band_sel,
    output logic                 adc_on,
    output logic                 search_done,
    output logic                 search_hit,
    output logic [BAND_W-1:0]    stat_band,
    output logic [CODE_W-1:0]    stat_code
);
    logic              trig;
    logic              busy;
    logic              load_timer;
    logic              expired;
    logic              success;
    logic              accept;
    logic              step_up;
    logic [BAND_W-1:0] cur_band;
    lock_class_t       cls;

    // Only a write to the fractional low byte starts a search.
    assign trig = div_wr_en && (div_wr_idx == REG_IDX_W'(FRAC_LO_IDX));

    vas_code_judge u_judge (
        .code    (adc_code),
        .cls     (cls),
        .accept  (accept),
        .step_up (step_up)
    );

    vas_settle_timer #(
        .CNT_W       (CNT_W),
        .DEFAULT_LEN (SETTLE_DEFAULT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_timer),
        .run     (busy),
        .len     (settle_len),
        .expired (expired)
    );

    vas_search_fsm #(
        .NUM_BANDS (NUM_BANDS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (auto_en),
        .trig       (trig),
        .seed       (seed_band),
        .expired    (expired),
        .accept     (accept),
        .step_up    (step_up),
        .busy       (busy),
        .load_timer (load_timer),
        .success    (success),
        .cur_band   (cur_band),
        .done_flag  (search_done),
        .hit_flag   (search_hit)
    );

    // Select the band source and gate the ADC for the active mode.
    assign band_sel = auto_en ? cur_band : seed_band;
    assign adc_on   = auto_en ? busy : adc_rd_en;

    // Publish the result on success, or on a manual latch in manual mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_band <= '0;
            stat_code <= '0;
        end else if (success) begin
            stat_band <= cur_band;
            stat_code <= adc_code;
        end else if (!auto_en && adc_rd_en && adc_latch) begin
            stat_code <= adc_code;
        end
    end

    AST_LATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !adc_rd_en) |=> $stable(stat_code)); // R11
    AST_PUBLISH_ONLY_VAS: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> (cls == CLS_VAS)); // R4
    AST_MANUAL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !$past(auto_en)) |-> !search_hit); // R2
endmodule

// File: tb/vco_band_search_test.sv
// Self-checking bench: a table of search scenarios, then directed tests.
module vco_band_search_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // seed, model, target, ok, band, code, visits
    localparam int VEC [NVEC][7] = '{
        '{ 5, 0,  9, 1,  9, 2,  5},
        '{20, 0, 12, 1, 12, 2,  9},
        '{ 7, 0,  7, 1,  7, 2,  1},
        '{ 3, 1,  6, 0,  0, 0,  5},
        '{18, 2,  0, 0,  0, 0,  6},
        '{ 2, 3,  0, 0,  0, 0,  3},
        '{10, 4, 14, 1, 14, 5,  5},
        '{ 0, 5,  3, 1,  3, 2,  4},
        '{23, 0,  0, 1,  0, 2, 24}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_en = 1'b1;
    logic [4:0]  seed_band = '0;
    logic        div_wr_en = 1'b0;
    logic [1:0]  div_wr_idx = '0;
    logic [15:0] settle_len = 16'd4;
    logic [2:0]  adc_code;
    logic        adc_rd_en = 1'b0;
    logic        adc_latch = 1'b0;
    logic [4:0]  band_sel;
    logic        adc_on;
    logic        search_done;
    logic        search_hit;
    logic [4:0]  stat_band;
    logic [2:0]  stat_code;

    int checks = 0;
    int errors = 0;
    int model = 0;
    int target = 0;
    int exp_band = 0;
    int exp_code = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vco_band_search uut (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .seed_band(seed_band),
        .div_wr_en(div_wr_en), .div_wr_idx(div_wr_idx), .settle_len(settle_len),
        .adc_code(adc_code), .adc_rd_en(adc_rd_en), .adc_latch(adc_latch),
        .band_sel(band_sel), .adc_on(adc_on), .search_done(search_done),
        .search_hit(search_hit), .stat_band(stat_band), .stat_code(stat_code)
    );

    // ADC model: the code seen for a band under the current scenario.
    function automatic logic [2:0] adc_model(int b, int m, int t);
        case (m)
            0, 4: begin
                if (b < t - 1) return 3'b000;
                if (b == t - 1) return 3'b001;
                if (b == t) return (m == 4) ? 3'b101 : 3'b010;
                if (b == t + 1) return 3'b110;
                return 3'b111;
            end
            1: return (b <= t) ? 3'b001 : 3'b110;
            2: return 3'b000;
            3: return 3'b111;
            default: begin
                if (b < t) return (b % 2 == 0) ? 3'b011 : 3'b100;
                if (b == t) return 3'b010;
                return 3'b111;
            end
        endcase
    endfunction

    always_comb adc_code = adc_model(int'(band_sel), model, target);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fire(input int s);
        @(negedge clk);
        seed_band = 5'(s);
        div_wr_en = 1'b1;
        div_wr_idx = 2'd2;
        @(negedge clk);
        div_wr_en = 1'b0;
    endtask

    // Wait for done; returns cycles since the trigger edge.
    task automatic wait_done(output int cyc, output int saw_busy);
        cyc = 0;
        saw_busy = (search_done == 1'b0) ? 1 : 0;
        while (search_done == 1'b0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int busy;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", int'(search_done), 1);
        chk("R1 hit", int'(search_hit), 0);
        chk("R1 band", int'(stat_band), 0);
        chk("R1 code", int'(stat_code), 0);

        // Table walk: R4, R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            model = VEC[i][1];
            target = VEC[i][2];
            fire(VEC[i][0]);
            wait_done(cyc, busy);
            chk("R7 busy during search", busy, 1);
            chk("R7 settle cycles", cyc, 4 * VEC[i][6]);
            if (VEC[i][3] == 1) begin
                exp_band = VEC[i][4];
                exp_code = VEC[i][5];
            end
            chk("R4/R6 hit flag", int'(search_hit), VEC[i][3]);
            chk("R4/R6 band readback", int'(stat_band), exp_band);
            chk("R4/R6 code readback", int'(stat_code), exp_code);
        end

        // R8: zero settle length means 256 cycles
        settle_len = 16'd0;
        model = 0; target = 9;
        fire(9);
        wait_done(cyc, busy);
        chk("R8 default settle", cyc, 256);
        settle_len = 16'd4;

        // R9: retrigger restarts from the new seed
        fire(5);
        repeat (6) @(negedge clk);
        fire(8);
        wait_done(cyc, busy);
        chk("R9 restart cycles", cyc, 8);
        chk("R9 band", int'(stat_band), 9);
        exp_band = 9; exp_code = 2;

        // R10: out-of-range seed fails at once
        fire(24);
        chk("R10 done stays high", int'(search_done), 1);
        chk("R10 hit", int'(search_hit), 0);
        chk("R10 band readback kept", int'(stat_band), exp_band);

        // R3: writes to other divider registers do not start a search
        held = int'(band_sel);
        held = held;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            seed_band = 5'd3;
            div_wr_en = 1'b1;
            div_wr_idx = 2'(k);
            @(negedge clk);
            div_wr_en = 1'b0;
            busy = 0;
            for (int j = 0; j < 10; j++) begin
                if (search_done == 1'b0) busy = 1;
                @(negedge clk);
            end
            chk("R3 no search started", busy, 0);
            chk("R3 band unchanged", int'(band_sel), held);
        end

        // R12: dropping enable aborts a running search
        model = 0; target = 9;
        fire(5);
        repeat (3) @(negedge clk);
        auto_en = 1'b0;
        @(negedge clk);
        chk("R12 done after abort", int'(search_done), 1);
        chk("R12 hit after abort", int'(search_hit), 0);
        chk("R2 manual band", int'(band_sel), 5);

        // R2 / R11: manual mode band and ADC latch
        model = 0; target = 13;
        seed_band = 5'd13;
        @(negedge clk);
        chk("R2 manual band follows seed", int'(band_sel), 13);
        chk("R2 hit low in manual", int'(search_hit), 0);
        chk("R11 adc off", int'(adc_on), 0);
        adc_latch = 1'b1;
        @(negedge clk);
        adc_latch = 1'b0;
        chk("R11 latch ignored without enable", int'(stat_code), exp_code);
        adc_rd_en = 1'b1;
        seed_band = 5'd15;
        @(negedge clk);
        chk("R11 adc on", int'(adc_on), 1);
        adc_latch = 1'b1;
        @(negedge clk);
        adc_latch = 1'b0;
        chk("R11 latch captures code", int'(stat_code), 7);
        adc_rd_en = 1'b0;
        seed_band = 5'd13;
        adc_latch = 1'b1;
        @(negedge clk);
        adc_latch = 1'b0;
        chk("R11 second latch ignored", int'(stat_code), 7);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule